// File: doc/BRIEF.md
# SRAM Retention Sequencer

This block sits between a synchronous static-RAM bus controller and the select, strobe, address and write-data pins of an asynchronous SRAM. It watches a supply-good flag from an outside voltage monitor and uses it to move the RAM into and out of a low-power data-retention mode.

While the supply is good, every host pin reaches the RAM unchanged in the same cycle. When the flag falls, the block does one of two things:

- If no access is open, it deselects the RAM at once.
- If an access is open, it lets that access finish first. A bounded wait caps how long this can take.

Once deselected, the guarding select is driven to its inactive level, the other select is parked where the mode needs it, and every remaining pin is frozen. After the flag returns, a recovery wait lasting a number of milliseconds must run out before the host is let back in. The same wait applies after reset.

The host pins form a valid/ready pair. An access is valid while the active-low select is low and the active-high select is high. `host_ready` is the ready. The back-pressure rules are:

- The host may open an access only while `host_ready` is high.
- Once `host_ready` falls, the host must finish the access in flight, release the select and open no new one until `host_ready` returns.

A parameter picks which select guards retention.

Top module: `sram_retention_seq`

## Requirements
- R1: After reset the block sits in retention: `host_ready`=0, `retain_flag`=1, `drain_busy`=0, `ram_sel`=0. With the active-low guard, `ram_sel_n`=1.
- R2: While `host_ready`=1, every `ram_*` pin equals the matching `host_*` pin in the same cycle.
- R3: With no open access, deselection happens on the clock edge SYNC_STAGES+1 after `supply_ok` falls. Counted from that edge, `retain_flag` reads 1 and `host_ready` reads 0.
- R4: If an access is open when the fall reaches the controller, the block enters a drain phase. In that phase `drain_busy`=1, `host_ready`=0 and the pins still pass through. Retention begins on the first edge that sees the access closed.
- R5: A drain that stays open is cut off after DRAIN_MAX cycles. Retention is then entered SYNC_STAGES+1+DRAIN_MAX edges after the fall.
- R6: In retention `ram_sel` is 0 in both guard modes. With GUARD=0 (active-high guard) `ram_sel_n` holds its frozen value. With GUARD=1 (active-low guard) `ram_sel_n` is 1.
- R7: In retention and recovery, `ram_we_n`, `ram_oe_n`, `ram_addr`, `ram_wdata` and `ram_wdata_en` hold the host values taken on the edge that left pass-through. Host pin changes have no effect on them.
- R8: `host_ready` rises exactly SYNC_STAGES+1+CLK_KHZ*RECOVER_MS edges after `supply_ok` rises in retention.
- R9: A fall of `supply_ok` during recovery sends the block back to retention. The next rise then needs the full R8 wait.
- R10: A rise of `supply_ok` during a drain does not cancel it. Retention is still entered. Counted from the edge that sees the access closed, `host_ready` rises 1+CLK_KHZ*RECOVER_MS edges later.
- R11: Exactly one of `host_ready` (pass-through), `drain_busy` (drain) and `retain_flag` (retention or recovery) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good flag from the monitor, asynchronous |
| host_sel_n | input | 1 | Host active-low select |
| host_sel | input | 1 | Host active-high select |
| host_we_n | input | 1 | Host write strobe, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| host_wdata_en | input | 1 | Host drives the data bus |
| host_ready | output | 1 | Accesses accepted (ready) |
| drain_busy | output | 1 | Waiting for the open access to close |
| retain_flag | output | 1 | RAM in retention or recovery |
| ram_sel_n | output | 1 | RAM active-low select |
| ram_sel | output | 1 | RAM active-high select |
| ram_we_n | output | 1 | RAM write strobe |
| ram_oe_n | output | 1 | RAM output enable |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | Write data toward the RAM |
| ram_wdata_en | output | 1 | Data bus drive enable toward the RAM |

## Verification
The in-line assertions assume three things about the inputs:

- Reset is low from time zero.
- The host pins are synchronous to `clk`.
- `supply_ok` may change at any time, since it passes through the synchronizer.

The drain bound is checked only as a ceiling. An access the host keeps open is legal and ends in a forced cut-off.

The stimulus meets these assumptions in the following ways:

- It changes every input a little after a rising edge.
- It holds each `supply_ok` level for more cycles than the synchronizer depth, so every change reaches the controller.
- It opens accesses only while `host_ready` is high, as the back-pressure rules require.

// File: rtl/sram_ret_pkg.sv
package sram_ret_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_RETAIN  = 2'd2,
    ST_RECOVER = 2'd3
  } ret_state_t;

  localparam int GUARD_ACTIVE_HIGH = 0;
  localparam int GUARD_ACTIVE_LOW  = 1;
endpackage

// File: rtl/sram_ret_sync.sv
module sram_ret_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sram_ret_ctrl.sv
module sram_ret_ctrl
  import sram_ret_pkg::*;
#(
  parameter int RECOVER_CYC = 20,
  parameter int DRAIN_MAX   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_good,
  input  logic       bus_active,
  output ret_state_t state
);
  localparam int RC_W = (RECOVER_CYC > 1) ? $clog2(RECOVER_CYC) : 1;
  localparam int DC_W = (DRAIN_MAX > 1) ? $clog2(DRAIN_MAX) : 1;
  localparam logic [RC_W-1:0] RCNT_LOAD = RC_W'(RECOVER_CYC - 1);
  localparam logic [DC_W-1:0] DCNT_LAST = DC_W'(DRAIN_MAX - 1);

  logic [RC_W-1:0] rcnt;
  logic [DC_W-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RETAIN;
      rcnt  <= '0;
      dcnt  <= '0;
    end else begin
      case (state)
        ST_NORMAL: begin
          if (!supply_good) begin
            state <= bus_active ? ST_DRAIN : ST_RETAIN;
            dcnt  <= '0;
          end
        end
        ST_DRAIN: begin
          if (!bus_active || dcnt == DCNT_LAST) state <= ST_RETAIN;
          else                                  dcnt  <= dcnt + 1'b1;
        end
        ST_RETAIN: begin
          if (supply_good) begin
            state <= ST_RECOVER;
            rcnt  <= RCNT_LOAD;
          end
        end
        ST_RECOVER: begin
          if (!supply_good)    state <= ST_RETAIN;
          else if (rcnt == '0) state <= ST_NORMAL;
          else                 rcnt  <= rcnt - 1'b1;
        end
        default: state <= ST_RETAIN;
      endcase
    end
  end

  // R8
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && $past(state) != ST_NORMAL) |->
      ($past(state) == ST_RECOVER && $past(rcnt) == '0 && $past(supply_good)));

  // R8
  recover_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER && $past(state) == ST_RECOVER) |->
      (rcnt == $past(rcnt) - 1'b1));

  // R9
  recover_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER && !supply_good) |=> state == ST_RETAIN);

  // R3
  normal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NORMAL && !supply_good) |=> state != ST_NORMAL);

  // R5
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DRAIN |-> dcnt <= DCNT_LAST);
endmodule

// File: rtl/sram_ret_pinmux.sv
module sram_ret_pinmux
  import sram_ret_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int GUARD  = GUARD_ACTIVE_HIGH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ret_state_t        state,
  input  logic              host_sel_n,
  input  logic              host_sel,
  input  logic              host_we_n,
  input  logic              host_oe_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wdata_en,
  output logic              ram_sel_n,
  output logic              ram_sel,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_wdata_en
);
  logic              pass;
  logic              hold_sel_n, hold_we_n, hold_oe_n, hold_wdata_en;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_wdata;

  assign pass = (state == ST_NORMAL) || (state == ST_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_sel_n    <= 1'b1;
      hold_we_n     <= 1'b1;
      hold_oe_n     <= 1'b1;
      hold_addr     <= '0;
      hold_wdata    <= '0;
      hold_wdata_en <= 1'b0;
    end else if (pass) begin
      hold_sel_n    <= host_sel_n;
      hold_we_n     <= host_we_n;
      hold_oe_n     <= host_oe_n;
      hold_addr     <= host_addr;
      hold_wdata    <= host_wdata;
      hold_wdata_en <= host_wdata_en;
    end
  end

  assign ram_we_n     = pass ? host_we_n     : hold_we_n;
  assign ram_oe_n     = pass ? host_oe_n     : hold_oe_n;
  assign ram_addr     = pass ? host_addr     : hold_addr;
  assign ram_wdata    = pass ? host_wdata    : hold_wdata;
  assign ram_wdata_en = pass ? host_wdata_en : hold_wdata_en;

  generate
    if (GUARD == GUARD_ACTIVE_LOW) begin : g_low_guard
      assign ram_sel_n = pass ? host_sel_n : 1'b1;
      assign ram_sel   = pass ? host_sel   : 1'b0;
    end else begin : g_high_guard
      assign ram_sel_n = pass ? host_sel_n : hold_sel_n;
      assign ram_sel   = pass ? host_sel   : 1'b0;
    end
  endgenerate

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && $past(!pass)) |->
      ($stable(ram_addr) && $stable(ram_wdata) && $stable(ram_we_n) &&
       $stable(ram_oe_n) && $stable(ram_wdata_en)));
endmodule

// File: rtl/sram_retention_seq.sv
module sram_retention_seq
  import sram_ret_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int CLK_KHZ     = 50000,
  parameter int RECOVER_MS  = 5,
  parameter int DRAIN_MAX   = 64,
  parameter int SYNC_STAGES = 2,
  parameter int GUARD       = GUARD_ACTIVE_HIGH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              host_sel_n,
  input  logic              host_sel,
  input  logic              host_we_n,
  input  logic              host_oe_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wdata_en,
  output logic              host_ready,
  output logic              drain_busy,
  output logic              retain_flag,
  output logic              ram_sel_n,
  output logic              ram_sel,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_wdata_en
);
  localparam int RECOVER_CYC = CLK_KHZ * RECOVER_MS;

  logic       supply_good;
  logic       bus_active;
  ret_state_t state;

  assign bus_active = !host_sel_n && host_sel;

  sram_ret_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (supply_ok),
    .sync_out (supply_good)
  );

  sram_ret_ctrl #(.RECOVER_CYC(RECOVER_CYC), .DRAIN_MAX(DRAIN_MAX)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_good (supply_good),
    .bus_active  (bus_active),
    .state       (state)
  );

  sram_ret_pinmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GUARD(GUARD)) u_pins (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state),
    .host_sel_n    (host_sel_n),
    .host_sel      (host_sel),
    .host_we_n     (host_we_n),
    .host_oe_n     (host_oe_n),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_wdata_en (host_wdata_en),
    .ram_sel_n     (ram_sel_n),
    .ram_sel       (ram_sel),
    .ram_we_n      (ram_we_n),
    .ram_oe_n      (ram_oe_n),
    .ram_addr      (ram_addr),
    .ram_wdata     (ram_wdata),
    .ram_wdata_en  (ram_wdata_en)
  );

  assign host_ready  = (state == ST_NORMAL);
  assign drain_busy  = (state == ST_DRAIN);
  assign retain_flag = (state == ST_RETAIN) || (state == ST_RECOVER);

  // R6
  guard_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retain_flag |-> (!ram_sel && (GUARD == GUARD_ACTIVE_HIGH || ram_sel_n)));

  // R11
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({host_ready, drain_busy, retain_flag}) == 1);

  // R2
  pass_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (ram_sel == host_sel && ram_sel_n == host_sel_n));
endmodule

// File: tb/sram_retention_seq_test.sv
module sram_retention_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int KHZ = 4;
  localparam int MS = 5;
  localparam int DMAX = 6;
  localparam int SYNC = 2;
  localparam int NREC = KHZ * MS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic h_sel_n = 1'b1, h_sel = 1'b0, h_we_n = 1'b1, h_oe_n = 1'b1, h_wen = 1'b0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;

  logic rdy, dbusy, rflag, r_sel_n, r_sel, r_we_n, r_oe_n, r_wen;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata;
  logic rdy2, dbusy2, rflag2, r2_sel_n, r2_sel, r2_we_n, r2_oe_n, r2_wen;
  logic [AW-1:0] r2_addr;
  logic [DW-1:0] r2_wdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_retention_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(KHZ), .RECOVER_MS(MS),
    .DRAIN_MAX(DMAX), .SYNC_STAGES(SYNC), .GUARD(0)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .host_sel_n(h_sel_n), .host_sel(h_sel), .host_we_n(h_we_n), .host_oe_n(h_oe_n),
    .host_addr(h_addr), .host_wdata(h_wdata), .host_wdata_en(h_wen),
    .host_ready(rdy), .drain_busy(dbusy), .retain_flag(rflag),
    .ram_sel_n(r_sel_n), .ram_sel(r_sel), .ram_we_n(r_we_n), .ram_oe_n(r_oe_n),
    .ram_addr(r_addr), .ram_wdata(r_wdata), .ram_wdata_en(r_wen));

  sram_retention_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(KHZ), .RECOVER_MS(MS),
    .DRAIN_MAX(DMAX), .SYNC_STAGES(SYNC), .GUARD(1)) uut_lo (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .host_sel_n(h_sel_n), .host_sel(h_sel), .host_we_n(h_we_n), .host_oe_n(h_oe_n),
    .host_addr(h_addr), .host_wdata(h_wdata), .host_wdata_en(h_wen),
    .host_ready(rdy2), .drain_busy(dbusy2), .retain_flag(rflag2),
    .ram_sel_n(r2_sel_n), .ram_sel(r2_sel), .ram_we_n(r2_we_n), .ram_oe_n(r2_oe_n),
    .ram_addr(r2_addr), .ram_wdata(r2_wdata), .ram_wdata_en(r2_wen));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic edges_to_ready(output int n);
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      tick();
      n++;
      if (rdy) break;
    end
  endtask

  task automatic edges_to_retain(output int n);
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      tick();
      n++;
      if (rflag) break;
    end
  endtask

  task automatic status3(input string tag, input int r, input int d, input int f);
    chk(tag, {rdy, dbusy, rflag}, {r[0], d[0], f[0]});
    chk(tag, {rdy2, dbusy2, rflag2}, {r[0], d[0], f[0]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    status3("R1 status", 0, 0, 1);
    chk("R1 ram_sel", r_sel, 0);
    chk("R1 lo ram_sel_n", r2_sel_n, 1);

    // R8 recovery wait after reset
    supply_ok = 1'b1;
    edges_to_ready(n);
    chk("R8 recovery edges", n, SYNC + 1 + NREC);
    chk("R8 lo ready", rdy2, 1);

    // R2 pass-through sweep
    for (int a = 0; a < 32; a++) begin
      for (int p = 0; p < 4; p++) begin
        h_addr = AW'(a); h_wdata = DW'(a * 3 + p);
        h_we_n = p[0]; h_oe_n = p[1]; h_wen = ~p[0];
        h_sel_n = a[0]; h_sel = a[1];
        #1;
        chk("R2 pins", {r_sel_n, r_sel, r_we_n, r_oe_n, r_addr, r_wdata, r_wen},
            {h_sel_n, h_sel, h_we_n, h_oe_n, h_addr, h_wdata, h_wen});
        chk("R2 lo pins", {r2_sel_n, r2_sel, r2_we_n, r2_oe_n, r2_addr, r2_wdata, r2_wen},
            {h_sel_n, h_sel, h_we_n, h_oe_n, h_addr, h_wdata, h_wen});
      end
    end
    tick();
    status3("R11 normal", 1, 0, 0);

    // R3 idle supply loss; frozen set-up: sel_n low, sel low (not an access)
    h_sel_n = 1'b0; h_sel = 1'b0; h_we_n = 1'b0; h_oe_n = 1'b1;
    h_addr = 5'h15; h_wdata = 4'hA; h_wen = 1'b1;
    tick();
    supply_ok = 1'b0;
    edges_to_retain(n);
    chk("R3 retain edges", n, SYNC + 1);
    status3("R3 status", 0, 0, 1);

    // R6 guard levels
    chk("R6 hi ram_sel", r_sel, 0);
    chk("R6 hi ram_sel_n frozen", r_sel_n, 0);
    chk("R6 lo ram_sel", r2_sel, 0);
    chk("R6 lo ram_sel_n", r2_sel_n, 1);

    // R7 host pin changes have no effect
    for (int k = 0; k < 32; k++) begin
      h_addr = AW'(k); h_wdata = DW'(k); h_we_n = k[0]; h_oe_n = k[1]; h_wen = k[2];
      h_sel_n = k[3]; h_sel = k[4];
      tick();
      chk("R7 frozen", {r_we_n, r_oe_n, r_addr, r_wdata, r_wen}, {1'b0, 1'b1, 5'h15, 4'hA, 1'b1});
      chk("R7 lo frozen", {r2_sel_n, r2_sel, r2_addr, r2_wdata}, {1'b1, 1'b0, 5'h15, 4'hA});
    end
    h_sel_n = 1'b1; h_sel = 1'b0;

    // R9 supply dip during recovery restarts the wait
    supply_ok = 1'b1;
    repeat (SYNC + 1 + 8) tick();
    status3("R9 mid recovery", 0, 0, 1);
    supply_ok = 1'b0;
    repeat (6) tick();
    status3("R9 after dip", 0, 0, 1);
    supply_ok = 1'b1;
    edges_to_ready(n);
    chk("R9 full wait", n, SYNC + 1 + NREC);

    // R4 drain with access that closes
    h_sel_n = 1'b0; h_sel = 1'b1; h_addr = 5'd3;
    tick();
    supply_ok = 1'b0;
    repeat (SYNC + 1) tick();
    status3("R4 drain status", 0, 1, 0);
    h_addr = 5'd9;
    #1;
    chk("R4 drain pass addr", r_addr, 9);
    h_sel_n = 1'b1; h_sel = 1'b0; h_addr = 5'd12;
    tick();
    status3("R4 retain after close", 0, 0, 1);
    chk("R4 frozen addr", r_addr, 12);

    supply_ok = 1'b1;
    edges_to_ready(n);
    chk("R8 second recovery", n, SYNC + 1 + NREC);

    // R5 drain timeout
    h_sel_n = 1'b0; h_sel = 1'b1;
    tick();
    supply_ok = 1'b0;
    edges_to_retain(n);
    chk("R5 timeout edges", n, SYNC + 1 + DMAX);
    chk("R5 ram_sel", r_sel, 0);
    h_sel_n = 1'b1; h_sel = 1'b0;
    supply_ok = 1'b1;
    edges_to_ready(n);
    chk("R5 recovery", n, SYNC + 1 + NREC);

    // R10 supply returns mid-drain
    h_sel_n = 1'b0; h_sel = 1'b1;
    tick();
    supply_ok = 1'b0;
    repeat (SYNC + 2) tick();
    supply_ok = 1'b1;
    repeat (3) tick();
    status3("R10 still draining", 0, 1, 0);
    h_sel_n = 1'b1; h_sel = 1'b0;
    edges_to_ready(n);
    chk("R10 edges to ready", n, 2 + NREC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule